// File: doc/BRIEF.md
# Core Event Priority Controller

This block sits between the core's event sources and the instruction sequencer. It watches sixteen request lines covering emulation, reset, the non-maskable interrupt, exceptions, hardware errors, the core timer and nine general-purpose interrupt levels. A request can arrive as a one-cycle pulse or as a held level from a peripheral router. The block turns each rising edge into a latched pending bit. It filters the pending bits through a mask, and offers the sequencer the single most urgent level that may preempt whatever is already being handled.

Level 0 is the most urgent and level 15 the least. Level 4 is a reserved slot that never becomes pending. The sequencer accepts the offered level with an acknowledge. That moves the level from pending to in-service, so only strictly more urgent levels can then nest on top of it. A return pulse at the end of a handler releases the most urgent in-service level. A software-raise port lets an instruction make any general level pending. By convention levels 14 and 15 are left for this use, and levels 7 to 13 serve peripherals.

Top module: `evt_prio_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, every pending and in-service bit is cleared, and `evt_valid_o` is 0 after that edge.
- R2: A 0-to-1 transition of `req_i[n]` between two edges sets `pend_o[n]` at the second edge. A line held high sets the bit only once.
- R3: Bit 4 of `pend_o` is always 0, and level 4 is never offered, whatever `req_i[4]` does.
- R4: A pending level n in the range 5 to 15 is offered only when `mask_i[n]` is 1. When the bit is 0 the level stays pending in `pend_o`. Levels 0 to 3 are offered regardless of `mask_i`.
- R5: Among the pending levels that pass the mask, the lowest-numbered one appears on `evt_lvl_o`.
- R6: `evt_valid_o` is 1 only when the chosen level is strictly lower in number than every set bit of `insvc_o`. A level equal to or above the most urgent in-service level waits.
- R7: When `ack_i` and `evt_valid_o` are both 1 at an edge, the offered level's `pend_o` bit clears and its `insvc_o` bit sets at that edge.
- R8: A `ret_i` pulse clears the lowest-numbered set bit of `insvc_o` at the edge. With no bit set, it changes nothing.
- R9: With `sw_raise_i` at 1, a `sw_lvl_i` value from 7 to 15 sets that pending bit at the edge. Values 0 to 6 are ignored.
- R10: `ack_i` while `evt_valid_o` is 0 changes neither `pend_o` nor `insvc_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 16 | Event request lines, bit n for level n |
| mask_i | input | 16 | Enable bits for levels 5 to 15 (1 = allowed) |
| sw_raise_i | input | 1 | Software raise strobe |
| sw_lvl_i | input | 4 | Level selected by the software raise |
| ack_i | input | 1 | Sequencer accepts the offered level |
| ret_i | input | 1 | Return from the current handler |
| evt_valid_o | output | 1 | A level is offered to the sequencer |
| evt_lvl_o | output | 4 | Number of the offered level |
| pend_o | output | 16 | Pending bitmap |
| insvc_o | output | 16 | In-service bitmap |

## Verification
A corrupted pending or in-service bit is visible on `pend_o` or `insvc_o` right after the edge that corrupts it. Its effect on arbitration shows on `evt_valid_o` and `evt_lvl_o` in the same cycle, because the offer is derived combinationally from registered state. The bench therefore compares the full bitmaps and the offer after every edge. It walks nested acceptance, release order, masking of both classes of level, the reserved slot, equal-level blocking and software raises. A missed clear or an extra set is caught within one cycle.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int NUM_LVL   = 16;
    localparam int LVL_W     = $clog2(NUM_LVL);
    localparam int RSVD_LVL  = 4;
    localparam int NMASK_TOP = 3;   // levels 0..NMASK_TOP bypass the mask
    localparam int GEN_BASE  = 7;   // first general-purpose level

    typedef logic [NUM_LVL-1:0] lvl_vec_t;
    typedef logic [LVL_W-1:0]   lvl_idx_t;

    typedef struct packed {
        logic     hit;
        lvl_idx_t idx;
    } pick_t;

    // Lowest-numbered set bit (most urgent level).
    function automatic pick_t pick_first(input lvl_vec_t v);
        pick_t p;
        p.hit = 1'b0;
        p.idx = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = lvl_idx_t'(i);
            end
        end
        return p;
    endfunction

    function automatic lvl_vec_t onehot(input lvl_idx_t i);
        return lvl_vec_t'(1) << i;
    endfunction
endpackage

// File: rtl/evt_pend.sv
module evt_pend
    import evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvl_vec_t req_i,
    input  logic     sw_raise_i,
    input  lvl_idx_t sw_lvl_i,
    input  logic     clr_v,
    input  lvl_idx_t clr_lvl,
    output lvl_vec_t pend
);
    lvl_vec_t req_q;
    lvl_vec_t set_vec;
    lvl_vec_t clr_vec;

    always_comb begin
        set_vec = req_i & ~req_q;
        if (sw_raise_i && (sw_lvl_i >= lvl_idx_t'(GEN_BASE)))
            set_vec = set_vec | onehot(sw_lvl_i);
        set_vec[RSVD_LVL] = 1'b0;
        clr_vec = clr_v ? onehot(clr_lvl) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            pend  <= '0;
        end else begin
            req_q <= req_i;
            // a fresh edge on the level being accepted wins over the clear
            pend  <= (pend & ~clr_vec) | set_vec;
        end
    end
endmodule

// File: rtl/evt_svc.sv
module evt_svc
    import evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     set_v,
    input  lvl_idx_t set_lvl,
    input  logic     ret_i,
    output lvl_vec_t insvc,
    output pick_t    top
);
    lvl_vec_t rel_vec;
    lvl_vec_t add_vec;

    always_comb begin
        top     = pick_first(insvc);
        rel_vec = (ret_i && top.hit) ? onehot(top.idx) : '0;
        add_vec = set_v ? onehot(set_lvl) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) insvc <= '0;
        else     insvc <= (insvc & ~rel_vec) | add_vec;
    end
endmodule

// File: rtl/evt_arb.sv
module evt_arb
    import evt_pkg::*;
(
    input  lvl_vec_t pend,
    input  lvl_vec_t mask,
    input  pick_t    svc_top,
    output logic     valid,
    output lvl_idx_t lvl
);
    lvl_vec_t pass_vec;
    lvl_vec_t elig;
    pick_t    win;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_pass
        if (g == RSVD_LVL) begin : g_rsvd
            assign pass_vec[g] = 1'b0;
        end else if (g <= NMASK_TOP) begin : g_fixed
            assign pass_vec[g] = 1'b1;
        end else begin : g_maskable
            assign pass_vec[g] = mask[g];
        end
    end

    always_comb begin
        elig  = pend & pass_vec;
        win   = pick_first(elig);
        valid = win.hit && (!svc_top.hit || (win.idx < svc_top.idx));
        lvl   = win.idx;
    end
endmodule

// File: rtl/evt_prio_ctrl.sv
module evt_prio_ctrl
    import evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NUM_LVL-1:0] req_i,
    input  logic [NUM_LVL-1:0] mask_i,
    input  logic             sw_raise_i,
    input  logic [LVL_W-1:0] sw_lvl_i,
    input  logic             ack_i,
    input  logic             ret_i,
    output logic             evt_valid_o,
    output logic [LVL_W-1:0] evt_lvl_o,
    output logic [NUM_LVL-1:0] pend_o,
    output logic [NUM_LVL-1:0] insvc_o
);
    logic     take;
    pick_t    svc_top;
    lvl_vec_t pend_w;
    lvl_vec_t insvc_w;
    logic     valid_w;
    lvl_idx_t lvl_w;

    assign take = ack_i && valid_w;

    evt_pend u_pend (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .sw_raise_i(sw_raise_i),
        .sw_lvl_i  (sw_lvl_i),
        .clr_v     (take),
        .clr_lvl   (lvl_w),
        .pend      (pend_w)
    );

    evt_svc u_svc (
        .clk    (clk),
        .rst    (rst),
        .set_v  (take),
        .set_lvl(lvl_w),
        .ret_i  (ret_i),
        .insvc  (insvc_w),
        .top    (svc_top)
    );

    evt_arb u_arb (
        .pend   (pend_w),
        .mask   (mask_i),
        .svc_top(svc_top),
        .valid  (valid_w),
        .lvl    (lvl_w)
    );

    assign evt_valid_o = valid_w;
    assign evt_lvl_o   = lvl_w;
    assign pend_o      = pend_w;
    assign insvc_o     = insvc_w;
endmodule

// File: rtl/evt_prio_chk.sv
module evt_prio_chk
    import evt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NUM_LVL-1:0] mask_i,
    input logic             ack_i,
    input logic             ret_i,
    input logic             evt_valid_o,
    input logic [LVL_W-1:0] evt_lvl_o,
    input logic [NUM_LVL-1:0] pend_o,
    input logic [NUM_LVL-1:0] insvc_o
);
    logic blocked;
    always_comb begin
        blocked = 1'b0;
        for (int i = 0; i < NUM_LVL; i++)
            if (insvc_o[i] && (i <= int'(evt_lvl_o))) blocked = 1'b1;
    end

    // R3
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !pend_o[RSVD_LVL] && !(evt_valid_o && evt_lvl_o == lvl_idx_t'(RSVD_LVL)));

    // R4
    mask_honour_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_valid_o && evt_lvl_o > lvl_idx_t'(NMASK_TOP)) |-> mask_i[evt_lvl_o]);

    // R5
    offer_pending_chk: assert property (@(posedge clk) disable iff (rst)
        evt_valid_o |-> pend_o[evt_lvl_o]);

    // R6
    strict_nest_chk: assert property (@(posedge clk) disable iff (rst)
        evt_valid_o |-> !blocked);

    // R7
    accept_marks_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && evt_valid_o) |=> insvc_o[$past(evt_lvl_o)]);

    // R8
    release_one_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !(ack_i && evt_valid_o) && (insvc_o != '0))
        |=> $countones(insvc_o) == $countones($past(insvc_o)) - 1);

    // R10
    idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !evt_valid_o && !ret_i) |=> $stable(insvc_o));
endmodule

bind evt_prio_ctrl evt_prio_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mask_i     (mask_i),
    .ack_i      (ack_i),
    .ret_i      (ret_i),
    .evt_valid_o(evt_valid_o),
    .evt_lvl_o  (evt_lvl_o),
    .pend_o     (pend_o),
    .insvc_o    (insvc_o)
);

// File: tb/tb_evt_prio_ctrl.sv
module tb_evt_prio_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 2000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] req_i = '0;
    logic [15:0] mask_i = 16'hFFFF;
    logic        sw_raise_i = 1'b0;
    logic [3:0]  sw_lvl_i = '0;
    logic        ack_i = 1'b0;
    logic        ret_i = 1'b0;
    logic        evt_valid_o;
    logic [3:0]  evt_lvl_o;
    logic [15:0] pend_o;
    logic [15:0] insvc_o;

    typedef struct {
        string       tag;
        logic        ev;
        logic [3:0]  el;
        logic [15:0] ep;
        logic [15:0] ei;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    logic done = 1'b0;
    logic [15:0] req_nx = '0;
    logic [15:0] mask_nx = 16'hFFFF;
    logic        rst_nx = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_prio_ctrl dut (
        .clk(clk), .rst(rst), .req_i(req_i), .mask_i(mask_i),
        .sw_raise_i(sw_raise_i), .sw_lvl_i(sw_lvl_i),
        .ack_i(ack_i), .ret_i(ret_i),
        .evt_valid_o(evt_valid_o), .evt_lvl_o(evt_lvl_o),
        .pend_o(pend_o), .insvc_o(insvc_o)
    );

    // driver: applies one cycle of stimulus and queues the state expected after the edge
    task automatic step(input string tag, input logic a, input logic r,
                        input logic sv, input logic [3:0] sl,
                        input logic ev, input logic [3:0] el,
                        input logic [15:0] ep, input logic [15:0] ei);
        exp_t it;
        @(negedge clk);
        rst = rst_nx; req_i = req_nx; mask_i = mask_nx;
        ack_i = a; ret_i = r; sw_raise_i = sv; sw_lvl_i = sl;
        it.tag = tag; it.ev = ev; it.el = el; it.ep = ep; it.ei = ei;
        exp_q.push_back(it);
        @(posedge clk);
    endtask

    // monitor: compares shortly after each edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            n_cmp++;
            if (evt_valid_o !== it.ev || pend_o !== it.ep || insvc_o !== it.ei ||
                (it.ev && evt_lvl_o !== it.el)) begin
                n_bad++;
                $display("FAIL %s: valid=%0b lvl=%0d pend=%h insvc=%h, expected valid=%0b lvl=%0d pend=%h insvc=%h",
                         it.tag, evt_valid_o, evt_lvl_o, pend_o, insvc_o,
                         it.ev, it.el, it.ep, it.ei);
            end
        end
    end

    initial begin
        // R1 reset state
        step("R1 reset", 0, 0, 0, 0, 0, 0, 16'h0000, 16'h0000);
        step("R1 reset", 0, 0, 0, 0, 0, 0, 16'h0000, 16'h0000);
        rst_nx = 1'b0;
        step("R1 idle", 0, 0, 0, 0, 0, 0, 16'h0000, 16'h0000);
        // R2 rising edge latches, R5 offer
        req_nx = 16'h0200;
        step("R2 edge 9", 0, 0, 0, 0, 1, 9, 16'h0200, 16'h0000);
        req_nx = 16'h1200;
        step("R5 lowest wins", 0, 0, 0, 0, 1, 9, 16'h1200, 16'h0000);
        // R7 accept; R6 12 cannot nest over 9; R2 held line not relatched
        step("R7 accept 9", 1, 0, 0, 0, 0, 0, 16'h1000, 16'h0200);
        // R3 reserved ignored; R6 nesting of level 2
        req_nx = 16'h1214;
        step("R3 R6 nest 2", 0, 0, 0, 0, 1, 2, 16'h1004, 16'h0200);
        step("R7 accept 2", 1, 0, 0, 0, 0, 0, 16'h1000, 16'h0204);
        step("R10 idle ack", 1, 0, 0, 0, 0, 0, 16'h1000, 16'h0204);
        // R8 release order
        step("R8 release 2", 0, 1, 0, 0, 0, 0, 16'h1000, 16'h0200);
        step("R8 release 9", 0, 1, 0, 0, 1, 12, 16'h1000, 16'h0000);
        // R4 mask blocks general level, not level 3
        mask_nx = 16'hEFFF;
        step("R4 mask 12", 0, 0, 0, 0, 0, 0, 16'h1000, 16'h0000);
        mask_nx = 16'hEFF7; req_nx = 16'h121C;
        step("R4 level 3 unmaskable", 0, 0, 0, 0, 1, 3, 16'h1008, 16'h0000);
        step("R7 accept 3", 1, 0, 0, 0, 0, 0, 16'h1000, 16'h0008);
        step("R8 release 3", 0, 1, 0, 0, 0, 0, 16'h1000, 16'h0000);
        // R9 software raise
        step("R9 raise 14", 0, 0, 1, 14, 1, 14, 16'h5000, 16'h0000);
        step("R9 R8 raise 5 ignored, empty ret", 0, 1, 1, 5, 1, 14, 16'h5000, 16'h0000);
        mask_nx = 16'hFFFF;
        step("R4 unmask 12", 0, 0, 0, 0, 1, 12, 16'h5000, 16'h0000);
        step("R7 accept 12", 1, 0, 0, 0, 0, 0, 16'h4000, 16'h1000);
        // R6 equal level waits
        req_nx = 16'h021C;
        step("R2 drop 12", 0, 0, 0, 0, 0, 0, 16'h4000, 16'h1000);
        req_nx = 16'h121C;
        step("R6 equal blocked", 0, 0, 0, 0, 0, 0, 16'h5000, 16'h1000);
        step("R8 R6 release 12", 0, 1, 0, 0, 1, 12, 16'h5000, 16'h0000);
        @(negedge clk); ack_i = 0; ret_i = 0; sw_raise_i = 0;
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule